// File: doc/BRIEF.md
# Glitch-Free Clock Source Selector with Cascaded Dividers

This block produces the system clock and the CPU clock of a small controller. It can take them from one of three sources: a fast internal oscillator, a slow internal oscillator, or an external clock that arrives on a shared pad. Software writes a source request, a system-divider code, a CPU-divider code and a pad-output mode through a simple write port clocked by an always-running register clock.

A source change is made without stopping the clocks. The change is committed only when the requested source reports ready. The switch then goes through a break-before-make handshake between the two clock domains, so the master clock never carries a shortened pulse. The master clock feeds a power-of-two system divider. The system clock feeds a power-of-two CPU divider. Each divider picks up a new ratio only at the end of a full output period.

While an internal oscillator is active, the shared pad can drive out the master clock or a divided copy of it. When the external source is selected or active, the pad is an input only.

Top module: `clksel_top`

## Requirements
- R1: After reset, `act_src` reads 00 (fast internal source), the system clock runs at the fast source divided by 2, the CPU clock runs at the system clock divided by 4, and `pin_oe` is low.
- R2: A system-divider code n (write address 01, data bits [2:0]) makes the system clock period 2^n master-clock periods, from 000 = /1 to 111 = /128.
- R3: A CPU-divider code (write address 10, data bits [1:0]) divides the system clock: 00 = /1, 01 = /2, 10 = /4, 11 = /8.
- R4: Source request codes (write address 00, data bits [1:0]) are 00 = fast internal, 01 = slow internal, 10 = external pad clock. A write of 11 is ignored, and the current selection and its clock stay as they were.
- R5: A request for a source whose ready input is low stays pending. The active source and the clock are unchanged until that ready input rises, and the switch then completes. Only one switch is in progress at a time.
- R6: At most one source is gated onto the master clock at any time, and no system-clock phase is shorter than half a period of the fastest source.
- R7: A new divider ratio takes effect only at the end of the current output period, so the high and low phases in progress when it is written both keep their old full length.
- R8: `act_src` changes only when the switch has completed, and it then equals the requested source.
- R9: The pad-output mode (write address 11, data bits [1:0]) drives `pin_out` with: 00 = off (`pin_oe` low), 01 = master clock, 10 = master clock / 2, 11 = master clock / 4. `pin_oe` is high only when the mode is not 00 and neither the target source nor the active source is the external one.
- R10: With the external source active, the master clock follows `ckpin_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Always-running register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 00 source, 01 system divider, 10 CPU divider, 11 pad mode |
| wr_data | input | SDIV_W | Write data |
| clk_hi | input | 1 | Fast internal oscillator |
| clk_lo | input | 1 | Slow internal oscillator |
| ckpin_in | input | 1 | Clock input from the shared pad |
| rdy_hi | input | 1 | Fast oscillator stable |
| rdy_lo | input | 1 | Slow oscillator stable |
| rdy_ext | input | 1 | External clock stable |
| sys_clk | output | 1 | Divided system clock |
| cpu_clk | output | 1 | Divided CPU clock |
| act_src | output | 2 | Source currently driving the master clock |
| pin_out | output | 1 | Clock driven toward the shared pad |
| pin_oe | output | 1 | Pad output enable |

## Verification
The assertions assume that every source clock keeps toggling from reset until the switch away from it has finished. They also assume that a ready input rises only for a source whose clock is already running, because the break-before-make handshake needs edges from both the old and the new source. The stimulus keeps all three oscillators running for the whole run. It drops only the slow source's ready flag, and only while that source is not active. After each configuration write it waits long enough for the dividers to reach a period boundary before it measures a period.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int NSRC  = 3;
  localparam int SRC_W = 2;

  localparam logic [SRC_W-1:0] SRC_HI  = 2'd0;
  localparam logic [SRC_W-1:0] SRC_LO  = 2'd1;
  localparam logic [SRC_W-1:0] SRC_EXT = 2'd2;
  localparam logic [SRC_W-1:0] SRC_RSV = 2'd3;

  localparam logic [1:0] ADR_SRC  = 2'd0;
  localparam logic [1:0] ADR_SDIV = 2'd1;
  localparam logic [1:0] ADR_CDIV = 2'd2;
  localparam logic [1:0] ADR_PIN  = 2'd3;

  localparam logic [1:0] PIN_OFF  = 2'd0;
  localparam logic [1:0] PIN_MCK  = 2'd1;
  localparam logic [1:0] PIN_MCK2 = 2'd2;
  localparam logic [1:0] PIN_MCK4 = 2'd3;
endpackage

// File: rtl/clksel_rst_sync.sv
module clksel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] q;
  logic [STAGES-1:0] q_d;

  always_comb q_d = {q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= q_d;
  end

  assign rst_n_o = q[STAGES-1];
endmodule

// File: rtl/clksel_gate.sv
module clksel_gate #(
  parameter bit ON_AT_RST   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic arst_n,
  input  logic want,
  output logic en,
  output logic gclk
);
  logic                   rst_n_l;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   en_d;

  clksel_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(src_clk), .arst_n(arst_n), .rst_n_o(rst_n_l)
  );

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], want};
    en_d   = sync_q[SYNC_STAGES-1];
  end

  // synchroniser in the source's own domain
  always_ff @(posedge src_clk or negedge rst_n_l) begin
    if (!rst_n_l) sync_q <= {SYNC_STAGES{ON_AT_RST}};
    else          sync_q <= sync_d;
  end

  // enable moves only while the source clock is low
  always_ff @(negedge src_clk or negedge rst_n_l) begin
    if (!rst_n_l) en <= ON_AT_RST;
    else          en <= en_d;
  end

  assign gclk = src_clk & en;
endmodule

// File: rtl/clksel_pow2_div.sv
module clksel_pow2_div #(
  parameter int               SEL_W    = 3,
  parameter logic [SEL_W-1:0] RST_CODE = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             clk_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic             rst_n_l;
  logic [SEL_W-1:0] s1_q, s2_q, s3_q;
  logic [SEL_W-1:0] cur_q, cur_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;
  logic [CNT_W-1:0] half_m1;
  logic             term;

  clksel_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n_l)
  );

  always_comb begin
    if (cur_q == '0) half_m1 = '0;
    else             half_m1 = (CNT_W'(1) << (cur_q - 1'b1)) - 1'b1;
    term  = (cur_q == '0) || ((cnt_q == half_m1) && !ph_q);
    cur_d = cur_q;
    cnt_d = cnt_q + 1'b1;
    ph_d  = ph_q;
    if (term) begin
      cnt_d = '0;
      ph_d  = 1'b1;
      if (s2_q == s3_q) cur_d = s3_q;
    end else if (cnt_q == half_m1) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n_l) begin
    if (!rst_n_l) begin
      s1_q  <= RST_CODE;
      s2_q  <= RST_CODE;
      s3_q  <= RST_CODE;
      cur_q <= RST_CODE;
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else begin
      s1_q  <= sel;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      cur_q <= cur_d;
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign clk_o = (cur_q == '0) ? clk : ph_q;
endmodule

// File: rtl/clksel_top.sv
module clksel_top
  import clksel_pkg::*;
#(
  parameter int                SDIV_W      = 3,
  parameter int                CDIV_W      = 2,
  parameter int                SYNC_STAGES = 2,
  parameter logic [SDIV_W-1:0] SDIV_RST    = 3'd1,
  parameter logic [CDIV_W-1:0] CDIV_RST    = 2'd2
) (
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [SDIV_W-1:0] wr_data,
  input  logic              clk_hi,
  input  logic              clk_lo,
  input  logic              ckpin_in,
  input  logic              rdy_hi,
  input  logic              rdy_lo,
  input  logic              rdy_ext,
  output logic              sys_clk,
  output logic              cpu_clk,
  output logic [SRC_W-1:0]  act_src,
  output logic              pin_out,
  output logic              pin_oe
);
  localparam int RDY_W = 1 << SRC_W;

  logic bus_rst_n;
  clksel_rst_sync #(.STAGES(SYNC_STAGES)) u_bus_rst (
    .clk(bus_clk), .arst_n(rst_n), .rst_n_o(bus_rst_n)
  );

  // register-domain state
  logic [SRC_W-1:0]  req_q, req_d, tgt_q, tgt_d, act_q, act_d;
  logic [SDIV_W-1:0] sdiv_q, sdiv_d;
  logic [CDIV_W-1:0] cdiv_q, cdiv_d;
  logic [1:0]        pmode_q, pmode_d;
  logic [NSRC-1:0]   rdy_s1, rdy_s, en_s1, en_s;
  logic [RDY_W-1:0]  rdy_x;

  logic [NSRC-1:0] src_clk, src_en, src_gclk, want;
  logic            mclk;

  assign src_clk = {ckpin_in, clk_lo, clk_hi};
  assign rdy_x   = {{(RDY_W-NSRC){1'b0}}, rdy_s};

  always_comb begin
    req_d   = req_q;
    tgt_d   = tgt_q;
    act_d   = act_q;
    sdiv_d  = sdiv_q;
    cdiv_d  = cdiv_q;
    pmode_d = pmode_q;
    if (wr_en) begin
      case (wr_addr)
        ADR_SRC:  if (wr_data[SRC_W-1:0] != SRC_RSV) req_d = wr_data[SRC_W-1:0];
        ADR_SDIV: sdiv_d  = wr_data;
        ADR_CDIV: cdiv_d  = wr_data[CDIV_W-1:0];
        default:  pmode_d = wr_data[1:0];
      endcase
    end
    // commit a pending request only when its source is ready and idle
    if ((req_q != tgt_q) && (act_q == tgt_q) && rdy_x[req_q]) tgt_d = req_q;
    // report the new source once its enable is the only one seen
    if (en_s == (NSRC'(1) << tgt_q)) act_d = tgt_q;
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      req_q   <= SRC_HI;
      tgt_q   <= SRC_HI;
      act_q   <= SRC_HI;
      sdiv_q  <= SDIV_RST;
      cdiv_q  <= CDIV_RST;
      pmode_q <= PIN_OFF;
      rdy_s1  <= '0;
      rdy_s   <= '0;
      en_s1   <= NSRC'(1);
      en_s    <= NSRC'(1);
    end else begin
      req_q   <= req_d;
      tgt_q   <= tgt_d;
      act_q   <= act_d;
      sdiv_q  <= sdiv_d;
      cdiv_q  <= cdiv_d;
      pmode_q <= pmode_d;
      rdy_s1  <= {rdy_ext, rdy_lo, rdy_hi};
      rdy_s   <= rdy_s1;
      en_s1   <= src_en;
      en_s    <= en_s1;
    end
  end

  // break-before-make source gates
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign want[i] = (tgt_q == SRC_W'(i)) &&
                     ((src_en & ~(NSRC'(1) << i)) == '0);
    clksel_gate #(.ON_AT_RST(i == 0), .SYNC_STAGES(SYNC_STAGES)) u_gate (
      .src_clk(src_clk[i]), .arst_n(rst_n), .want(want[i]),
      .en(src_en[i]), .gclk(src_gclk[i])
    );
  end

  assign mclk = |src_gclk;

  clksel_pow2_div #(.SEL_W(SDIV_W), .RST_CODE(SDIV_RST)) u_sdiv (
    .clk(mclk), .arst_n(rst_n), .sel(sdiv_q), .clk_o(sys_clk)
  );

  clksel_pow2_div #(.SEL_W(CDIV_W), .RST_CODE(CDIV_RST)) u_cdiv (
    .clk(sys_clk), .arst_n(rst_n), .sel(cdiv_q), .clk_o(cpu_clk)
  );

  // pad output divider in the master-clock domain
  logic       m_rst_n;
  logic [1:0] pcnt_q, pcnt_d;

  clksel_rst_sync #(.STAGES(SYNC_STAGES)) u_m_rst (
    .clk(mclk), .arst_n(rst_n), .rst_n_o(m_rst_n)
  );

  always_comb pcnt_d = pcnt_q + 1'b1;

  always_ff @(posedge mclk or negedge m_rst_n) begin
    if (!m_rst_n) pcnt_q <= '0;
    else          pcnt_q <= pcnt_d;
  end

  always_comb begin
    case (pmode_q)
      PIN_MCK:  pin_out = mclk;
      PIN_MCK2: pin_out = pcnt_q[0];
      PIN_MCK4: pin_out = pcnt_q[1];
      default:  pin_out = 1'b0;
    endcase
  end

  assign pin_oe  = (pmode_q != PIN_OFF) && (tgt_q != SRC_EXT) && (act_q != SRC_EXT);
  assign act_src = act_q;
endmodule

// File: rtl/clksel_checks.sv
module clksel_checks (
  input logic       bus_clk,
  input logic       rst_n,
  input logic [1:0] act_src,
  input logic [1:0] tgt_src,
  input logic [2:0] en_vec,
  input logic [3:0] rdy_ok,
  input logic       pin_oe
);
  logic [3:0] rdy_d;
  always_ff @(posedge bus_clk) rdy_d <= rdy_ok;

  // R6: never two sources on the master clock
  a_r6_one_source: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $onehot0(en_vec));

  // R4: the reserved code never becomes a selection
  a_r4_no_reserved: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (tgt_src != 2'd3) && (act_src != 2'd3));

  // R5: a selection is committed only to a ready source
  a_r5_commit_ready: assert property (@(posedge bus_clk) disable iff (!rst_n)
    !$stable(tgt_src) |-> rdy_d[tgt_src]);

  // R5: no new commit while a switch is in flight
  a_r5_one_switch: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (act_src != tgt_src) |=> $stable(tgt_src));

  // R8: the status moves only onto the committed target
  a_r8_status_follows: assert property (@(posedge bus_clk) disable iff (!rst_n)
    !$stable(act_src) |-> (act_src == tgt_src));

  // R9: pad never driven while the external clock is active
  a_r9_pad_input_ext: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (act_src == 2'd2) |-> !pin_oe);
endmodule

bind clksel_top clksel_checks u_chk (
  .bus_clk(bus_clk),
  .rst_n(bus_rst_n),
  .act_src(act_q),
  .tgt_src(tgt_q),
  .en_vec(src_en),
  .rdy_ok(rdy_x),
  .pin_oe(pin_oe)
);

// File: tb/clksel_top_test.sv
`timescale 1ns/1ps
module clksel_top_test;
  logic       bus_clk, rst_n, wr_en;
  logic [1:0] wr_addr;
  logic [2:0] wr_data;
  logic       clk_hi, clk_lo, ckpin_in, rdy_hi, rdy_lo, rdy_ext;
  logic       sys_clk, cpu_clk, pin_out, pin_oe;
  logic [1:0] act_src;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // periods in ns: fast 10, slow 80, external 30
  initial bus_clk  = 0; always #2.5 bus_clk  = ~bus_clk;
  initial clk_hi   = 0; always #5   clk_hi   = ~clk_hi;
  initial clk_lo   = 0; always #40  clk_lo   = ~clk_lo;
  initial ckpin_in = 0; always #15  ckpin_in = ~ckpin_in;

  clksel_top uut (
    .bus_clk(bus_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .clk_hi(clk_hi), .clk_lo(clk_lo), .ckpin_in(ckpin_in),
    .rdy_hi(rdy_hi), .rdy_lo(rdy_lo), .rdy_ext(rdy_ext), .sys_clk(sys_clk),
    .cpu_clk(cpu_clk), .act_src(act_src), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct packed {
    logic [1:0] src;
    logic [2:0] sd;
    logic [1:0] cd;
    int         sp;
    int         cp;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{2'd0, 3'd0, 2'd0,   10,   10},
    '{2'd0, 3'd3, 2'd1,   80,  160},
    '{2'd1, 3'd0, 2'd2,   80,  320},
    '{2'd1, 3'd2, 2'd3,  320, 2560},
    '{2'd2, 3'd1, 2'd0,   60,   60},
    '{2'd2, 3'd0, 2'd3,   30,  240},
    '{2'd0, 3'd7, 2'd0, 1280, 1280},
    '{2'd0, 3'd1, 2'd2,   20,   80}
  };

  // phase-width monitor for R6
  bit      mon_en = 0;
  realtime t_edge = 0;
  realtime min_ph = 1.0e9;
  always @(sys_clk) begin
    if (mon_en && (t_edge > 0) && ($realtime - t_edge < min_ph)) min_ph = $realtime - t_edge;
    t_edge = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    @(negedge bus_clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge bus_clk);
    wr_en = 0;
  endtask

  task automatic per_sys(output int p);
    realtime t0;
    @(posedge sys_clk); t0 = $realtime;
    @(posedge sys_clk); p = int'($realtime - t0);
  endtask

  task automatic per_cpu(output int p);
    realtime t0;
    @(posedge cpu_clk); t0 = $realtime;
    @(posedge cpu_clk); p = int'($realtime - t0);
  endtask

  task automatic per_pin(output int p);
    realtime t0;
    @(posedge pin_out); t0 = $realtime;
    @(posedge pin_out); p = int'($realtime - t0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #900000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int p;
    realtime t0, t1;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    rdy_hi = 1; rdy_lo = 1; rdy_ext = 1;
    #53 rst_n = 1;
    #1000;
    mon_en = 1;

    // R1: reset state
    #1.3;
    chk(act_src == 2'd0, "R1", "act_src", act_src, 0);
    chk(pin_oe == 1'b0, "R1", "pin_oe", pin_oe, 0);
    per_sys(p); chk(p == 20, "R1", "sys period", p, 20);
    per_cpu(p); chk(p == 80, "R1", "cpu period", p, 80);

    // R2 R3 R8 R10: table of configurations
    for (int i = 0; i < 8; i++) begin
      wr(2'd2, {1'b0, TBL[i].cd});
      #5000;
      wr(2'd0, {1'b0, TBL[i].src});
      wr(2'd1, TBL[i].sd);
      #12000;
      @(negedge bus_clk);
      chk(act_src == TBL[i].src, "R8", "act_src", act_src, TBL[i].src);
      per_sys(p); chk(p == TBL[i].sp, "R2", "sys period", p, TBL[i].sp);
      per_cpu(p); chk(p == TBL[i].cp, "R3", "cpu period", p, TBL[i].cp);
    end

    // R7: ratio change mid-period keeps full phases (fast source, /128 -> /1)
    wr(2'd1, 3'd7);
    #3000;
    @(posedge sys_clk); t0 = $realtime;
    #100;
    wr(2'd1, 3'd0);
    @(negedge sys_clk); t1 = $realtime;
    chk(int'(t1 - t0) == 640, "R7", "high phase", int'(t1 - t0), 640);
    @(posedge sys_clk);
    chk(int'($realtime - t1) == 640, "R7", "low phase", int'($realtime - t1), 640);
    per_sys(p); chk(p == 10, "R7", "new period", p, 10);

    // R5: pending request while slow source not ready
    rdy_lo = 0;
    #200;
    wr(2'd0, 3'd1);
    #3000;
    @(negedge bus_clk);
    chk(act_src == 2'd0, "R5", "act_src pending", act_src, 0);
    per_sys(p); chk(p == 10, "R5", "sys period pending", p, 10);
    rdy_lo = 1;
    #20;
    @(negedge bus_clk);
    chk(act_src == 2'd0, "R8", "act_src before completion", act_src, 0);
    #3000;
    @(negedge bus_clk);
    chk(act_src == 2'd1, "R5", "act_src after ready", act_src, 1);
    per_sys(p); chk(p == 80, "R5", "sys period after ready", p, 80);

    // R4: reserved code ignored
    wr(2'd0, 3'd3);
    #3000;
    @(negedge bus_clk);
    chk(act_src == 2'd1, "R4", "act_src after code 11", act_src, 1);
    per_sys(p); chk(p == 80, "R4", "sys period after code 11", p, 80);

    // back to fast source, /2 system divider
    wr(2'd0, 3'd0);
    wr(2'd1, 3'd1);
    #5000;

    // R9: pad output modes
    wr(2'd3, 3'd1);
    #200;
    @(negedge bus_clk);
    chk(pin_oe == 1'b1, "R9", "pin_oe mode 01", pin_oe, 1);
    per_pin(p); chk(p == 10, "R9", "pad period mode 01", p, 10);
    wr(2'd3, 3'd2);
    #200;
    per_pin(p); chk(p == 20, "R9", "pad period mode 10", p, 20);
    wr(2'd3, 3'd3);
    #200;
    per_pin(p); chk(p == 40, "R9", "pad period mode 11", p, 40);

    // R9 R10: external source releases the pad
    wr(2'd3, 3'd1);
    wr(2'd0, 3'd2);
    #3000;
    @(negedge bus_clk);
    chk(act_src == 2'd2, "R10", "act_src external", act_src, 2);
    chk(pin_oe == 1'b0, "R9", "pin_oe with external", pin_oe, 0);
    per_sys(p); chk(p == 60, "R10", "sys period external /2", p, 60);

    wr(2'd0, 3'd0);
    wr(2'd3, 3'd0);
    #3000;
    @(negedge bus_clk);
    chk(pin_oe == 1'b0, "R9", "pin_oe mode 00", pin_oe, 0);

    // R6: no runt phase over the whole run
    chk(min_ph > 4.9, "R6", "min sys phase ps", longint'(min_ph * 1000), 5000);

    finish_run();
  end
endmodule